// File: doc/BRIEF.md
# Decimal Accumulator Processor

This block is a small multicycle processor built around one accumulator. Its instructions are three-digit decimal words taken from a 100-word internal memory. The hundreds digit of a word selects the operation. The lower two digits name a mailbox address. Every memory word and the accumulator hold a binary integer from 0 to 999. The processor has arithmetic, load and store, two conditional branches, an input port, an output port and a stop instruction.

Before a run, the memory is filled through a load port while the processor sits idle after reset. A one-cycle start pulse then begins execution at address 0. Each instruction takes several cycles: fetch the word at the counter, decode it and advance the counter, then execute.

The input and output ports use a valid/ready handshake, and the processor stalls on them without a time limit. When the program stops, or when an illegal word is met, the processor asserts a halted status. An illegal word also asserts an error flag. Both flags hold until reset.

Top module: `decimal_acc_cpu`

## Requirements
- R1: After reset the counter and accumulator are 0, the negative flag is clear, `halted`, `error`, `in_ready` and `out_valid` are low, and the processor stays idle until `start` is pulsed. It then fetches its first word from address 0.
- R2: Words execute in address order. The counter is advanced past a word before that word executes, and it wraps from 99 back to 0.
- R3: A word 5xx loads the accumulator from mailbox xx. A word 3xx writes the accumulator into mailbox xx.
- R4: A word 1xx adds mailbox xx to the accumulator modulo 1000, and clears the negative flag.
- R5: A word 2xx subtracts mailbox xx from the accumulator modulo 1000. A subtraction that borrows sets the negative flag. A subtraction that does not borrow leaves the flag unchanged. The flag is cleared only by a load, an input or an add.
- R6: A word 7xx sets the counter to xx when the accumulator equals 0. Otherwise execution continues at the next word.
- R7: A word 8xx sets the counter to xx when the negative flag is clear, and a zero accumulator counts as positive. When the flag is set, execution continues at the next word.
- R8: The word 901 raises `in_ready` and waits until `in_valid` is high. The accepted `in_data` goes into the accumulator, reduced by 1000 if it exceeds 999, and the negative flag is cleared. `in_ready` and `out_valid` are never high together.
- R9: The word 902 presents the accumulator on `out_data` with `out_valid` high. Both stay unchanged until `out_ready` is seen, and `out_valid` drops on the cycle after the handshake.
- R10: The word 000 stops execution. `halted` then stays high, with `error` low and no further output, until reset.
- R11: The words 4xx and 6xx, and any 9xx other than 901 and 902, stop execution with both `halted` and `error` high.
- R12: The load port writes `ld_data` into the word at `ld_addr` only while the processor is idle. A load request made during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory load strobe (used only while idle) |
| ld_addr | input | 7 | Word address for a load |
| ld_data | input | 10 | Word value for a load, 0 to 999 |
| start | input | 1 | Leaves idle and begins execution at address 0 |
| in_data | input | 10 | Input value |
| in_valid | input | 1 | Input value is offered |
| in_ready | output | 1 | Processor is waiting for input |
| out_data | output | 10 | Output value |
| out_valid | output | 1 | Output value is offered |
| out_ready | input | 1 | Consumer takes the output |
| halted | output | 1 | Execution has stopped; held until reset |
| error | output | 1 | Stop was caused by an illegal word |

## Verification
The arithmetic path is driven from a table of operand pairs. Each program inputs two values, combines them, outputs the result and then branches on the sign, so one run shows both the modulo-1000 value and the state of the negative flag.

The pairs cover the following cases:
- a plain sum
- a sum that wraps past 999
- a sum that lands exactly on 0
- a subtraction with no borrow
- a subtraction that gives exactly 0
- two subtractions that borrow

Together these separate a wrong wrap constant from a wrong borrow test. Directed programs then cover the rest:
- a taken and a not-taken zero branch
- a borrow followed by a non-borrowing subtraction, to show the flag is sticky
- a wrap of the counter from 99 to 0
- stalls on both ports
- a load request made mid-run
- halt and illegal words

// File: rtl/dac_pkg.sv
package dac_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DEC,
    S_EXEC,
    S_DATA,
    S_INW,
    S_OUTW,
    S_HALT
  } cpu_state_t;

  localparam logic [3:0] OP_HLT = 4'd0;
  localparam logic [3:0] OP_ADD = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_STA = 4'd3;
  localparam logic [3:0] OP_LDA = 4'd5;
  localparam logic [3:0] OP_BRZ = 4'd7;
  localparam logic [3:0] OP_BRP = 4'd8;
  localparam logic [3:0] OP_IO  = 4'd9;

  localparam int IO_IN  = 1;
  localparam int IO_OUT = 2;

endpackage

// File: rtl/dac_mem.sv
module dac_mem #(
  parameter int WORDS = 100,
  parameter int VW    = 10,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [VW-1:0] wdata,
  output logic [VW-1:0] rdata
);

  logic [VW-1:0] store [WORDS];

  // single port, read-before-write, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end

endmodule

// File: rtl/dac_alu.sv
module dac_alu #(
  parameter int VW   = 10,
  parameter int VMOD = 1000
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  input  logic          sub,
  output logic [VW-1:0] res,
  output logic          borrow
);

  logic [VW:0] sum_w;

  always_comb begin
    sum_w  = {1'b0, a} + {1'b0, b};
    borrow = 1'b0;
    if (sub) begin
      if (a >= b) begin
        res = a - b;
      end else begin
        res    = VW'(VMOD) - b + a;
        borrow = 1'b1;
      end
    end else if (sum_w >= (VW+1)'(VMOD)) begin
      res = VW'(sum_w - (VW+1)'(VMOD));
    end else begin
      res = sum_w[VW-1:0];
    end
  end

endmodule

// File: rtl/dac_dec.sv
module dac_dec #(
  parameter int VW    = 10,
  parameter int AW    = 7,
  parameter int RADIX = 100,
  parameter int NOPS  = 10
) (
  input  logic [VW-1:0] word,
  output logic [3:0]    op,
  output logic [AW-1:0] adr
);

  int base;
  int rem;

  // the hundreds digit is found by threshold compares, with no divider
  always_comb begin
    op   = '0;
    base = 0;
    for (int k = 1; k < NOPS; k++) begin
      if (int'(word) >= k * RADIX) begin
        op   = 4'(k);
        base = k * RADIX;
      end
    end
    rem = int'(word) - base;
    adr = AW'(rem);
  end

endmodule

// File: rtl/decimal_acc_cpu.sv
module decimal_acc_cpu #(
  parameter int WORDS = 100,
  parameter int VMOD  = 1000,
  parameter int VW    = $clog2(VMOD),
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [VW-1:0] ld_data,
  input  logic          start,
  input  logic [VW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [VW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          halted,
  output logic          error
);
  import dac_pkg::*;

  localparam int NOPS = VMOD / WORDS;
  localparam logic [AW-1:0] PC_LAST = AW'(WORDS - 1);

  cpu_state_t    state;
  logic [AW-1:0] pc;
  logic [VW-1:0] acc;
  logic          neg;
  logic [3:0]    op_q;
  logic [AW-1:0] adr_q;
  logic          halted_q, error_q, in_ready_q, out_valid_q;
  logic [VW-1:0] out_data_q;

  logic          m_we;
  logic [AW-1:0] m_addr;
  logic [VW-1:0] m_wd, m_rd;
  logic [3:0]    d_op;
  logic [AW-1:0] d_adr;
  logic [VW-1:0] alu_res;
  logic          alu_borrow;

  // memory port: load port while idle, otherwise counter or operand address
  always_comb begin
    m_we   = 1'b0;
    m_addr = pc;
    m_wd   = acc;
    if (state == S_IDLE) begin
      m_we   = ld_en;
      m_addr = ld_addr;
      m_wd   = ld_data;
    end else if (state == S_EXEC) begin
      m_addr = adr_q;
      m_we   = (op_q == OP_STA);
    end
  end

  dac_mem #(.WORDS(WORDS), .VW(VW), .AW(AW)) u_mem (
    .clk(clk), .we(m_we), .addr(m_addr), .wdata(m_wd), .rdata(m_rd)
  );

  dac_dec #(.VW(VW), .AW(AW), .RADIX(WORDS), .NOPS(NOPS)) u_dec (
    .word(m_rd), .op(d_op), .adr(d_adr)
  );

  dac_alu #(.VW(VW), .VMOD(VMOD)) u_alu (
    .a(acc), .b(m_rd), .sub(op_q == OP_SUB), .res(alu_res), .borrow(alu_borrow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      pc          <= '0;
      acc         <= '0;
      neg         <= 1'b0;
      op_q        <= '0;
      adr_q       <= '0;
      halted_q    <= 1'b0;
      error_q     <= 1'b0;
      in_ready_q  <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      case (state)
        S_IDLE:  if (start && !ld_en) state <= S_FETCH;
        S_FETCH: state <= S_DEC;
        S_DEC: begin
          op_q  <= d_op;
          adr_q <= d_adr;
          pc    <= (pc == PC_LAST) ? '0 : pc + 1'b1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (op_q)
            OP_HLT: begin
              halted_q <= 1'b1;
              state    <= S_HALT;
            end
            OP_ADD, OP_SUB, OP_LDA: state <= S_DATA;
            OP_STA: ;
            OP_BRZ: if (acc == '0) pc <= adr_q;
            OP_BRP: if (!neg) pc <= adr_q;
            OP_IO: begin
              if (int'(adr_q) == IO_IN) begin
                in_ready_q <= 1'b1;
                state      <= S_INW;
              end else if (int'(adr_q) == IO_OUT) begin
                out_valid_q <= 1'b1;
                out_data_q  <= acc;
                state       <= S_OUTW;
              end else begin
                halted_q <= 1'b1;
                error_q  <= 1'b1;
                state    <= S_HALT;
              end
            end
            default: begin
              halted_q <= 1'b1;
              error_q  <= 1'b1;
              state    <= S_HALT;
            end
          endcase
        end
        S_DATA: begin
          state <= S_FETCH;
          if (op_q == OP_LDA) begin
            acc <= m_rd;
            neg <= 1'b0;
          end else begin
            acc <= alu_res;
            if (op_q == OP_ADD) neg <= 1'b0;
            else if (alu_borrow) neg <= 1'b1;
          end
        end
        S_INW: if (in_valid) begin
          acc        <= (int'(in_data) >= VMOD) ? in_data - VW'(VMOD) : in_data;
          neg        <= 1'b0;
          in_ready_q <= 1'b0;
          state      <= S_FETCH;
        end
        S_OUTW: if (out_ready) begin
          out_valid_q <= 1'b0;
          state       <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign in_ready  = in_ready_q;
  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign halted    = halted_q;
  assign error     = error_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R10
  AST_ERROR_HALTS: assert property (@(posedge clk) disable iff (rst)
    error |-> halted); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready); // R8
  AST_IO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid)); // R8
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(acc) < VMOD); // R4
  AST_PC_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(pc) < WORDS); // R2

endmodule

// File: tb/decimal_acc_cpu_test.sv
module decimal_acc_cpu_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMO = 3000;

  typedef struct packed {
    int a;
    int b;
    int sub;
    int exp;
    int pos;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3,   4,   0, 7,   1},
    '{600, 500, 0, 100, 1},
    '{999, 1,   0, 0,   1},
    '{10,  3,   1, 7,   1},
    '{5,   5,   1, 0,   1},
    '{3,   5,   1, 998, 0},
    '{0,   1,   1, 999, 0},
    '{123, 0,   0, 123, 1}
  };

  logic       clk = 0;
  logic       rst = 1;
  logic       ld_en = 0;
  logic [6:0] ld_addr = '0;
  logic [9:0] ld_data = '0;
  logic       start = 0;
  logic [9:0] in_data = '0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [9:0] out_data;
  logic       out_valid;
  logic       out_ready = 0;
  logic       halted;
  logic       error;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  decimal_acc_cpu uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .halted(halted), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, act=%0d exp=<150000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic load_word(input int a, input int v);
    @(negedge clk);
    ld_en = 1; ld_addr = 7'(a); ld_data = 10'(v);
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic fresh();
    do_reset();
    for (int i = 0; i < 100; i++) load_word(i, 0);
  endtask

  task automatic go();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic feed_in(input int v, input string tag);
    int n = 0;
    while (!in_ready && n < TMO) begin @(negedge clk); n++; end
    check(int'(in_ready), 1, tag);
    in_valid = 1; in_data = 10'(v);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic get_out(input int exp, input string tag);
    int n = 0;
    while (!out_valid && n < TMO) begin @(negedge clk); n++; end
    if (!out_valid) check(0, 1, {tag, " out_valid timeout"});
    else check(int'(out_data), exp, tag);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < TMO) begin @(negedge clk); n++; end
  endtask

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    check(int'(halted), 0, "R1 halted after reset");
    check(int'(error), 0, "R1 error after reset");
    check(int'(in_ready), 0, "R1 in_ready after reset");
    check(int'(out_valid), 0, "R1 out_valid after reset");
    repeat (10) @(negedge clk);
    check(int'(halted), 0, "R1 idle until start");

    // R1: first word fetched from address 0
    fresh();
    load_word(0, 902);
    load_word(1, 0);
    go();
    get_out(0, "R1 first word at 0, acc reset to 0");
    wait_halt();
    check(int'(halted), 1, "R1 program stops");

    // table of operand pairs: R3 R4 R5 R7
    foreach (VECS[i]) begin
      fresh();
      load_word(0, 901);  load_word(1, 399);
      load_word(2, 901);  load_word(3, 398);
      load_word(4, 599);
      load_word(5, (VECS[i].sub != 0) ? 298 : 198);
      load_word(6, 902);  load_word(7, 811);
      load_word(8, 596);  load_word(9, 902);  load_word(10, 0);
      load_word(11, 595); load_word(12, 902); load_word(13, 0);
      load_word(95, 555); load_word(96, 444);
      go();
      feed_in(VECS[i].a, "R8 input a");
      feed_in(VECS[i].b, "R8 input b");
      get_out(VECS[i].exp, (VECS[i].sub != 0) ? "R5 subtract result" : "R4 add result");
      get_out((VECS[i].pos != 0) ? 555 : 444, "R7 sign branch");
      wait_halt();
      check(int'(error), 0, "R3 store/load program ends cleanly");
    end

    // R6: zero branch taken and not taken
    for (int t = 0; t < 2; t++) begin
      fresh();
      load_word(0, 901); load_word(1, 705); load_word(2, 902); load_word(3, 0);
      load_word(5, 595); load_word(6, 902); load_word(7, 0);
      load_word(95, 555);
      go();
      feed_in((t == 0) ? 0 : 7, "R8 input for zero branch");
      get_out((t == 0) ? 555 : 7, "R6 zero branch");
    end

    // R5: flag sticky across non-borrowing subtract, cleared by add
    for (int t = 0; t < 2; t++) begin
      fresh();
      load_word(0, 901); load_word(1, 299);
      load_word(2, (t == 0) ? 298 : 198);
      load_word(3, 811); load_word(4, 596); load_word(5, 902); load_word(6, 0);
      load_word(11, 595); load_word(12, 902); load_word(13, 0);
      load_word(99, 5); load_word(98, 0); load_word(95, 555); load_word(96, 444);
      go();
      feed_in(3, "R8 input for flag test");
      get_out((t == 0) ? 444 : 555, (t == 0) ? "R5 flag sticky" : "R5 add clears flag");
    end

    // R2: counter wraps from 99 to 0
    fresh();
    load_word(0, 798);  load_word(1, 196); load_word(2, 902); load_word(3, 0);
    load_word(98, 597); load_word(99, 902);
    load_word(97, 321); load_word(96, 444);
    go();
    get_out(321, "R2 branch to 98 then sequential");
    get_out(765, "R2 counter wraps 99 to 0");

    // R8, R9, R10, R12: stalls, clamp, mid-run load ignored, halt
    fresh();
    load_word(0, 901); load_word(1, 902); load_word(2, 0);
    go();
    repeat (12) @(negedge clk);
    check(int'(in_ready), 1, "R8 waits for input");
    check(int'(out_valid), 0, "R8 no output while waiting");
    ld_en = 1; ld_addr = 7'd1; ld_data = 10'd0;
    @(negedge clk);
    ld_en = 0;
    feed_in(1005, "R8 input accepted");
    @(negedge clk);
    check(int'(in_ready), 0, "R8 in_ready drops after accept");
    begin
      int n = 0;
      while (!out_valid && n < TMO) begin @(negedge clk); n++; end
    end
    check(int'(out_data), 5, "R8 input above 999 reduced; R12 load ignored");
    repeat (6) @(negedge clk);
    check(int'(out_valid), 1, "R9 out_valid held");
    check(int'(out_data), 5, "R9 out_data held");
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check(int'(out_valid), 0, "R9 out_valid drops after handshake");
    wait_halt();
    check(int'(halted), 1, "R10 halt reached");
    check(int'(error), 0, "R10 no error on halt");
    repeat (20) @(negedge clk);
    check(int'(halted), 1, "R10 halted stays high");
    check(int'(out_valid), 0, "R10 no output after halt");

    // R11: illegal words
    for (int t = 0; t < 3; t++) begin
      fresh();
      load_word(0, (t == 0) ? 400 : ((t == 1) ? 650 : 950));
      load_word(1, 902);
      go();
      wait_halt();
      check(int'(halted), 1, "R11 illegal word halts");
      check(int'(error), 1, "R11 illegal word raises error");
      repeat (5) @(negedge clk);
      check(int'(out_valid), 0, "R11 nothing executes after illegal word");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule